// File: doc/BRIEF.md
# Dual-Rail Word Link with Code-Based Completion

This block carries an N-bit word across a channel in which every data bit occupies two wires. The sending half takes a single-rail word when it is idle. It puts the dual-rail codeword on its 2N rails and keeps it there until the receiving side acknowledges. It then drives every rail low, the spacer, and waits for the acknowledge to drop before it takes another word. The exchange is a four-phase handshake. The channel therefore alternates between a full codeword and the all-spacer state.

The receiving half samples the rails into a register and classifies each bit pair. It raises `rx_complete` when every pair holds a valid code and `rx_empty` when every pair is the spacer. It raises `rx_error` when any pair shows the forbidden both-high value. Its acknowledge follows completion up and emptiness down. The decoded word is captured only at the moment completion rises. No strobe or matched delay is involved: word boundaries are read from the code itself. The two halves are exposed separately, so the receiver can be fed from the sender or from any other rail source.

Top module: `dr_link`

## Requirements
- R1: Bit i of a word is carried on rails [2i+1:2i]: a 0 is sent as the pair 2'b10 and a 1 as 2'b01. The sender has 2*WIDTH rails.
- R2: The sender never drives a pair to 2'b11. Its rails are either all low or a complete codeword.
- R3: When `tx_ready` is high and `tx_start` is sampled high, the codeword appears on `tx_rails` one cycle later. It stays there until `tx_ack` is sampled high, and the rails go to all-spacer on the following cycle. `tx_ready` returns one cycle after `tx_ack` is sampled low. In loopback, `tx_ready` comes back 7 cycles after the start cycle.
- R4: `rx_complete` is high one cycle after `rx_rails` carry a valid code (01 or 10) on every pair. A word with any pair still at spacer is not complete.
- R5: `rx_empty` is high one cycle after every pair of `rx_rails` is 2'b00.
- R6: `rx_error` is high one cycle after any pair of `rx_rails` reads 2'b11. Such a pair also blocks completion.
- R7: `rx_ack` rises one cycle after `rx_complete` is high and falls one cycle after `rx_empty` is high. Otherwise it holds its value.
- R8: `rx_word` is loaded with the decoded word, where bit i equals rail 2i, in the cycle that `rx_ack` rises, which is one cycle after completion rises. At all other times it holds its value.
- R9: `tx_start` is ignored while `tx_ready` is low. No extra word is sent afterwards.
- R10: After reset, `tx_ready` is 1 and `tx_rails`, `rx_ack`, `rx_complete` and `rx_word` are 0, and `rx_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Request to send `tx_word` |
| tx_word | input | WIDTH | Single-rail word to send |
| tx_ready | output | 1 | Sender idle and able to take a word |
| tx_rails | output | 2*WIDTH | Dual-rail channel driven by the sender |
| tx_ack | input | 1 | Acknowledge seen by the sender |
| rx_rails | input | 2*WIDTH | Dual-rail channel seen by the receiver |
| rx_ack | output | 1 | Receiver acknowledge |
| rx_complete | output | 1 | Every pair holds a valid code |
| rx_empty | output | 1 | Every pair is spacer |
| rx_error | output | 1 | Some pair reads 11 |
| rx_word | output | WIDTH | Last decoded word |

## Verification
In loopback, the codeword is due on the rails one cycle after the start cycle and stays for three cycles. The spacer then follows for three cycles, and `tx_ready` returns on the seventh cycle. The bench samples each of those cycles on the falling edge and compares it with the expected value. The receiver's flags are due one cycle after new rail values, and acknowledge and word one cycle after that. The injected sequences change the rails one step at a time and check the flags on the next falling edge. A monitor pops the scoreboard on the falling edge where `rx_ack` has just risen, the cycle in which the word is due.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    PAIR_NULL = 2'b00,
    PAIR_ONE  = 2'b01,
    PAIR_ZERO = 2'b10,
    PAIR_BAD  = 2'b11
  } pair_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'b00,
    TX_DATA = 2'b01,
    TX_RTZ  = 2'b10
  } tx_state_t;
endpackage

// File: rtl/dr_pair_class.sv
module dr_pair_class
  import dr_pkg::*;
(
  input  logic [1:0] pair_i,
  output logic       valid_o,
  output logic       null_o,
  output logic       bad_o,
  output logic       bit_o
);
  always_comb begin
    valid_o = 1'b0;
    null_o  = 1'b0;
    bad_o   = 1'b0;
    case (pair_t'(pair_i))
      PAIR_NULL: null_o  = 1'b1;
      PAIR_ONE,
      PAIR_ZERO: valid_o = 1'b1;
      default:   bad_o   = 1'b1;
    endcase
    bit_o = pair_i[0];
  end
endmodule

// File: rtl/dr_tx.sv
module dr_tx
  import dr_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int RAILS = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             ack_i,
  output logic             ready_o,
  output logic [RAILS-1:0] rails_o
);
  tx_state_t        state_q, state_d;
  logic [RAILS-1:0] rails_q, rails_d;
  logic [RAILS-1:0] code;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      code[2*i+1 -: 2] = word_i[i] ? PAIR_ONE : PAIR_ZERO;
    end
  end

  always_comb begin
    state_d = state_q;
    rails_d = rails_q;
    unique case (state_q)
      TX_IDLE: if (start_i) begin
        state_d = TX_DATA;
        rails_d = code;
      end
      TX_DATA: if (ack_i) begin
        state_d = TX_RTZ;
        rails_d = '0;
      end
      TX_RTZ: if (!ack_i) state_d = TX_IDLE;
      default: begin
        state_d = TX_IDLE;
        rails_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      rails_q <= '0;
    end else begin
      state_q <= state_d;
      rails_q <= rails_d;
    end
  end

  assign ready_o = (state_q == TX_IDLE);
  assign rails_o = rails_q;

  logic [WIDTH-1:0] pair_hi, pair_lo;
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      pair_hi[i] = rails_o[2*i+1];
      pair_lo[i] = rails_o[2*i];
    end
  end

  // R2
  no_bad_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_hi & pair_lo) == '0);
  // R2
  whole_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rails_o != '0) |-> ((pair_hi | pair_lo) == {WIDTH{1'b1}}));
  // R3
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rails_o != '0 && !ack_i) |=> $stable(rails_o));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && rails_o == '0) |=> (rails_o == '0));
endmodule

// File: rtl/dr_rx.sv
module dr_rx #(
  parameter int WIDTH = 8,
  localparam int RAILS = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAILS-1:0] rails_i,
  output logic             ack_o,
  output logic             complete_o,
  output logic             empty_o,
  output logic             error_o,
  output logic [WIDTH-1:0] word_o
);
  logic [RAILS-1:0] rails_q;
  logic [WIDTH-1:0] valid_v, null_v, bad_v, bit_v;
  logic             complete_d_q;
  logic             ack_d;
  logic [WIDTH-1:0] word_q, word_d;
  logic             ack_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pair
    dr_pair_class u_cls (
      .pair_i  (rails_q[2*g+1 -: 2]),
      .valid_o (valid_v[g]),
      .null_o  (null_v[g]),
      .bad_o   (bad_v[g]),
      .bit_o   (bit_v[g])
    );
  end

  assign complete_o = &valid_v;
  assign empty_o    = &null_v;
  assign error_o    = |bad_v;

  always_comb begin
    ack_d  = ack_q;
    word_d = word_q;
    if (complete_o)   ack_d = 1'b1;
    else if (empty_o) ack_d = 1'b0;
    if (complete_o && !complete_d_q) word_d = bit_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rails_q      <= '0;
      complete_d_q <= 1'b0;
      ack_q        <= 1'b0;
      word_q       <= '0;
    end else begin
      rails_q      <= rails_i;
      complete_d_q <= complete_o;
      ack_q        <= ack_d;
      word_q       <= word_d;
    end
  end

  assign ack_o  = ack_q;
  assign word_o = word_q;

  // R7
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(complete_o));
  // R7
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> $past(empty_o));
  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o) |-> ($past(complete_o) && !$past(complete_d_q)));
  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(complete_o && empty_o));
  // R6
  bad_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !complete_o);
endmodule

// File: rtl/dr_link.sv
module dr_link #(
  parameter int WIDTH = 8,
  localparam int RAILS = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_start,
  input  logic [WIDTH-1:0] tx_word,
  output logic             tx_ready,
  output logic [RAILS-1:0] tx_rails,
  input  logic             tx_ack,
  input  logic [RAILS-1:0] rx_rails,
  output logic             rx_ack,
  output logic             rx_complete,
  output logic             rx_empty,
  output logic             rx_error,
  output logic [WIDTH-1:0] rx_word
);
  dr_tx #(.WIDTH(WIDTH)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (tx_start),
    .word_i  (tx_word),
    .ack_i   (tx_ack),
    .ready_o (tx_ready),
    .rails_o (tx_rails)
  );

  dr_rx #(.WIDTH(WIDTH)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rails_i    (rx_rails),
    .ack_o      (rx_ack),
    .complete_o (rx_complete),
    .empty_o    (rx_empty),
    .error_o    (rx_error),
    .word_o     (rx_word)
  );
endmodule

// File: tb/dr_link_tb.sv
module dr_link_tb;
  localparam int W = 8;
  localparam int R = 2 * W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tx_start = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic         tx_ready, tx_ack, rx_ack, rx_complete, rx_empty, rx_error;
  logic [R-1:0] tx_rails, rx_rails;
  logic [W-1:0] rx_word;
  logic         inj = 1'b0;
  logic [R-1:0] inj_rails = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] sb[$];
  logic prev_ack = 1'b0;

  always #4 clk = ~clk;

  assign rx_rails = inj ? inj_rails : tx_rails;
  assign tx_ack   = rx_ack;

  dr_link #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_word(tx_word),
    .tx_ready(tx_ready), .tx_rails(tx_rails), .tx_ack(tx_ack),
    .rx_rails(rx_rails), .rx_ack(rx_ack), .rx_complete(rx_complete),
    .rx_empty(rx_empty), .rx_error(rx_error), .rx_word(rx_word)
  );

  function automatic logic [R-1:0] enc(input logic [W-1:0] w);
    logic [R-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = w[i] ? 2'b01 : 2'b10;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Scoreboard monitor: the word is due in the cycle rx_ack rises (R8)
  always @(negedge clk) begin
    if (rst_n && !inj && rx_ack && !prev_ack) begin
      if (sb.size() == 0) check(1'b0, "R8 unexpected word", {24'd0, rx_word}, 32'd0);
      else begin
        logic [W-1:0] e;
        e = sb.pop_front();
        check(rx_word == e, "R8 scoreboard word", {24'd0, rx_word}, {24'd0, e});
      end
    end
    prev_ack <= rx_ack;
  end

  task automatic send(input logic [W-1:0] w, input bit poke);
    logic [R-1:0] c;
    c = enc(w);
    sb.push_back(w);
    tx_word  = w;
    tx_start = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      if (i == 1) tx_start = 1'b0;
      if (poke && i == 2) begin tx_start = 1'b1; tx_word = ~w; end
      if (poke && i == 3) tx_start = 1'b0;
      if (i <= 3) check(tx_rails == c, "R1 R3 codeword held", {16'd0, tx_rails}, {16'd0, c});
      else        check(tx_rails == '0, "R3 spacer phase", {16'd0, tx_rails}, 32'd0);
      check(tx_ready == (i == 7), "R3 ready timing", {31'd0, tx_ready}, {31'd0, i == 7});
    end
    @(negedge clk);
    check(tx_rails == '0, "R9 no extra word after busy start", {16'd0, tx_rails}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(tx_ready == 1'b1, "R10 ready", {31'd0, tx_ready}, 32'd1);
    check(tx_rails == '0, "R10 rails", {16'd0, tx_rails}, 32'd0);
    check(rx_ack == 1'b0 && rx_complete == 1'b0, "R10 ack/complete", {30'd0, rx_ack, rx_complete}, 32'd0);
    check(rx_empty == 1'b1, "R10 empty", {31'd0, rx_empty}, 32'd1);
    check(rx_word == '0, "R10 word", {24'd0, rx_word}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    send(8'h00, 1'b0);
    send(8'hFF, 1'b0);
    send(8'hA5, 1'b1);   // R9 start poked while busy
    send(8'h5A, 1'b0);
    send(8'h01, 1'b0);
    send(8'h80, 1'b0);
    check(rx_word == 8'h80, "R8 last word held", {24'd0, rx_word}, 32'h80);

    // Injected rails: partial word, then full, then illegal, then spacer
    inj = 1'b1;
    inj_rails = {14'd0, 2'b10};
    @(negedge clk);
    check(!rx_complete && !rx_empty && !rx_error, "R4 partial word not complete",
          {29'd0, rx_complete, rx_empty, rx_error}, 32'd0);
    inj_rails = enc(8'h3C);
    @(negedge clk);
    check(rx_complete == 1'b1, "R4 complete", {31'd0, rx_complete}, 32'd1);
    check(rx_ack == 1'b0 && rx_word == 8'h80, "R8 word not yet loaded",
          {23'd0, rx_ack, rx_word}, {23'd0, 1'b0, 8'h80});
    @(negedge clk);
    check(rx_ack == 1'b1, "R7 ack rises", {31'd0, rx_ack}, 32'd1);
    check(rx_word == 8'h3C, "R8 decoded word", {24'd0, rx_word}, 32'h3C);
    inj_rails = enc(8'h3C) | (R'(2'b11) << 4);
    @(negedge clk);
    check(rx_error == 1'b1 && rx_complete == 1'b0, "R6 illegal pair",
          {30'd0, rx_error, rx_complete}, 32'd2);
    check(rx_ack == 1'b1, "R7 ack held", {31'd0, rx_ack}, 32'd1);
    @(negedge clk);
    check(rx_word == 8'h3C, "R8 word held through error", {24'd0, rx_word}, 32'h3C);
    inj_rails = '0;
    @(negedge clk);
    check(rx_empty == 1'b1 && rx_error == 1'b0, "R5 empty", {30'd0, rx_empty, rx_error}, 32'd2);
    check(rx_ack == 1'b1, "R7 ack before fall", {31'd0, rx_ack}, 32'd1);
    @(negedge clk);
    check(rx_ack == 1'b0, "R7 ack falls", {31'd0, rx_ack}, 32'd0);
    inj = 1'b0;
    @(negedge clk);

    send(8'h96, 1'b0);
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R8 scoreboard drained", sb.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule